// File: doc/BRIEF.md
# Vector Length Control Register

This block holds the vector length requested by the most privileged software level and derives from it the length the vector datapath actually uses. Software sets the request through a system-register write and reads it back through a system-register read. Each access arrives as a five-field register encoding, a read/write flag, the current privilege level and a trap-enable bit owned by a separate control register. The block sorts every access into one of four outcomes: not addressed to it, accepted, undefined, or trapped.

The stored request is a 4-bit code `len`, and the requested length is (len+1)*128 bits. The datapath length is the largest supported power of two, from 128 up to 2048 bits, that does not exceed the request. The set of supported lengths comes from a mask input and is capped by a parameter for the largest implemented length. The datapath length is given in the same code form, 2^k-1 for 128*2^k bits. A read always returns the stored code as it was written, not the rounded one.

Top module: `vlen_ctl_reg`

## Requirements
- R1: After reset the stored code is 0, reads return 0, and `eff_len` is 0 (128 bits).
- R2: An accepted write (encoding matches, `req_el`=3, `trap_en`=1, `req_wr`=1) stores `wr_data[3:0]` at the clock edge. Bits [63:4] of the write data are dropped.
- R3: An accepted read (`req_wr`=0) raises `rd_vld` in the same cycle. `rd_data[3:0]` holds the stored code and bits [63:4] are zero, including the read-as-zero field at [8:4].
- R4: A request is recognised only when op0=2'b11, op1=3'b110, crn=4'b0001, crm=4'b0010 and op2=3'b000. Any other request raises no output and leaves the stored code unchanged.
- R5: A recognised request with `req_el` of 0, 1 or 2 raises `undef`. It raises neither `rd_vld` nor `trap`, and does not write.
- R6: A recognised request with `req_el`=3 while `trap_en`=0 raises `trap` with `trap_class`=6'h19. It neither reads nor writes.
- R7: `eff_len` is 2^k-1, where k is the largest value in 0..MAX_K with 2^k <= len+1 and with that size supported. Size 0 (128 bits) is always supported. Size k>=1 is supported when `sup_mask[k-1]`=1.
- R8: After an accepted write, `eff_len` reflects the new code in the next cycle, with no extra latency.
- R9: `trap_class` is 0 whenever `trap` is low. At most one of `rd_vld`, `undef` and `trap` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Access request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Current privilege level, 3 = top |
| trap_en | input | 1 | Access enable from the other control register; 0 traps |
| wr_data | input | 64 | Write data |
| sup_mask | input | 4 | Bit j marks 256*2^j bits as supported |
| rd_data | output | 64 | Read data, zero unless `rd_vld` |
| rd_vld | output | 1 | Read accepted |
| undef | output | 1 | Access undefined at this privilege level |
| trap | output | 1 | Access trapped to the top level |
| trap_class | output | 6 | Syndrome class, 6'h19 with `trap` |
| eff_len | output | 4 | Effective length code for the datapath |

## Verification
On every cycle the assertions check that the outcome of each access is consistent. Only one outcome fires, the trap class goes with the trap, a read returns the raw stored code, accepted writes land while undefined and trapped ones leave the store alone, and `eff_len` stays a power-of-two code no larger than the request. The exact rounding under particular supported-length masks, with partial masks picking a smaller size, needs the bench's scenarios. So do the masking of write data above bit 3 and the point at which `eff_len` changes relative to the write edge. The random mix of privilege levels, enable values, encodings and masks, with directed corner cases added, covers these.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  localparam int VL_DATA_W  = 64;
  localparam int VL_LEN_W   = 4;
  localparam int VL_SIZES   = 5;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b110;
  localparam logic [3:0] ENC_CRN = 4'b0001;
  localparam logic [3:0] ENC_CRM = 4'b0010;
  localparam logic [2:0] ENC_OP2 = 3'b000;

  localparam logic [1:0] PRIV_TOP   = 2'd3;
  localparam logic [5:0] TRAP_CLASS = 6'h19;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_OK    = 2'd1,
    ACC_UNDEF = 2'd2,
    ACC_TRAP  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/vlen_access_decode.sv
module vlen_access_decode
  import vlen_pkg::*;
(
  input  logic       req_vld,
  input  logic [1:0] req_op0,
  input  logic [2:0] req_op1,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_op2,
  input  logic [1:0] req_el,
  input  logic       trap_en,
  output acc_kind_e  kind
);
  logic enc_hit;

  always_comb begin
    enc_hit = (req_op0 == ENC_OP0) && (req_op1 == ENC_OP1) &&
              (req_crn == ENC_CRN) && (req_crm == ENC_CRM) &&
              (req_op2 == ENC_OP2);
  end

  always_comb begin
    kind = ACC_NONE;
    if (req_vld && enc_hit) begin
      if (req_el != PRIV_TOP) begin
        kind = ACC_UNDEF;
      end else if (!trap_en) begin
        kind = ACC_TRAP;
      end else begin
        kind = ACC_OK;
      end
    end
  end
endmodule

// File: rtl/vlen_len_store.sv
module vlen_len_store #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LEN_W-1:0] len_q
);
  logic [LEN_W-1:0] len_d;

  always_comb begin
    len_d = len_q;
    if (wr_en) begin
      len_d = wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (wr_en) begin
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/vlen_round.sv
module vlen_round #(
  parameter int LEN_W = 4,
  parameter int SIZES = 5,
  parameter int MAX_K = 4
) (
  input  logic [LEN_W-1:0] len,
  input  logic [SIZES-2:0] sup_mask,
  output logic [LEN_W-1:0] eff_len
);
  localparam int UNITS_W = LEN_W + 1;
  localparam int K_W     = $clog2(SIZES);

  logic [UNITS_W-1:0] units;
  logic [SIZES-1:0]   fits;
  logic [K_W-1:0]     best_k;

  assign units = {1'b0, len} + UNITS_W'(1);

  genvar gk;
  generate
    for (gk = 0; gk < SIZES; gk++) begin : g_size
      if (gk == 0) begin : g_base
        assign fits[gk] = 1'b1;
      end else if (gk > MAX_K) begin : g_absent
        assign fits[gk] = 1'b0;
      end else begin : g_opt
        assign fits[gk] = sup_mask[gk-1] && (units >= UNITS_W'(1 << gk));
      end
    end
  endgenerate

  always_comb begin
    best_k = '0;
    for (int k = 0; k < SIZES; k++) begin
      if (fits[k]) begin
        best_k = K_W'(k);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LEN_W; i++) begin
      eff_len[i] = (i < int'(best_k));
    end
  end
endmodule

// File: rtl/vlen_ctl_reg.sv
module vlen_ctl_reg
  import vlen_pkg::*;
#(
  parameter int DATA_W = VL_DATA_W,
  parameter int LEN_W  = VL_LEN_W,
  parameter int MAX_K  = VL_SIZES - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic                 req_wr,
  input  logic [1:0]           req_op0,
  input  logic [2:0]           req_op1,
  input  logic [3:0]           req_crn,
  input  logic [3:0]           req_crm,
  input  logic [2:0]           req_op2,
  input  logic [1:0]           req_el,
  input  logic                 trap_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [VL_SIZES-2:0]  sup_mask,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_vld,
  output logic                 undef,
  output logic                 trap,
  output logic [5:0]           trap_class,
  output logic [LEN_W-1:0]     eff_len
);
  acc_kind_e        kind;
  logic             wr_en;
  logic [LEN_W-1:0] len_q;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:LEN_W];

  vlen_access_decode u_dec (
    .req_vld (req_vld),
    .req_op0 (req_op0),
    .req_op1 (req_op1),
    .req_crn (req_crn),
    .req_crm (req_crm),
    .req_op2 (req_op2),
    .req_el  (req_el),
    .trap_en (trap_en),
    .kind    (kind)
  );

  assign wr_en = (kind == ACC_OK) && req_wr;

  vlen_len_store #(.LEN_W(LEN_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_len (wr_data[LEN_W-1:0]),
    .len_q  (len_q)
  );

  vlen_round #(.LEN_W(LEN_W), .SIZES(VL_SIZES), .MAX_K(MAX_K)) u_round (
    .len      (len_q),
    .sup_mask (sup_mask),
    .eff_len  (eff_len)
  );

  always_comb begin
    rd_vld     = (kind == ACC_OK) && !req_wr;
    undef      = (kind == ACC_UNDEF);
    trap       = (kind == ACC_TRAP);
    trap_class = trap ? TRAP_CLASS : 6'h00;
    rd_data    = '0;
    if (rd_vld) begin
      rd_data = {{(DATA_W-LEN_W){1'b0}}, len_q};
    end
  end
endmodule

// File: rtl/vlen_ctl_reg_chk.sv
module vlen_ctl_reg_chk #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_wr,
  input logic [1:0]        req_op0,
  input logic [2:0]        req_op1,
  input logic [3:0]        req_crn,
  input logic [3:0]        req_crm,
  input logic [2:0]        req_op2,
  input logic [1:0]        req_el,
  input logic              trap_en,
  input logic [LEN_W-1:0]  wr_len,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_vld,
  input logic              undef,
  input logic              trap,
  input logic [5:0]        trap_class,
  input logic [LEN_W-1:0]  eff_len,
  input logic [LEN_W-1:0]  len_q
);
  logic hit;
  assign hit = req_vld && req_op0 == 2'b11 && req_op1 == 3'b110 &&
               req_crn == 4'b0001 && req_crm == 4'b0010 && req_op2 == 3'b000;

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_wr && req_el == 2'd3 && trap_en |=> len_q == $past(wr_len));

  a_r3_read_raw: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> rd_data == {{(DATA_W-LEN_W){1'b0}}, len_q});

  a_r4_no_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !rd_vld && !undef && !trap);

  a_r5_low_priv_undef: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_el != 2'd3 |-> undef && !trap && !rd_vld);

  a_r5_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> $stable(len_q));

  a_r6_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_el == 2'd3 && !trap_en |-> trap && trap_class == 6'h19 && !rd_vld);

  a_r6_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> $stable(len_q));

  a_r7_eff_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    eff_len <= len_q && $countones({1'b0, eff_len} + 5'd1) == 1);

  a_r9_class_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> trap_class == 6'h00);

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_vld, undef, trap}));
endmodule

bind vlen_ctl_reg vlen_ctl_reg_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_wr     (req_wr),
  .req_op0    (req_op0),
  .req_op1    (req_op1),
  .req_crn    (req_crn),
  .req_crm    (req_crm),
  .req_op2    (req_op2),
  .req_el     (req_el),
  .trap_en    (trap_en),
  .wr_len     (wr_data[LEN_W-1:0]),
  .rd_data    (rd_data),
  .rd_vld     (rd_vld),
  .undef      (undef),
  .trap       (trap),
  .trap_class (trap_class),
  .eff_len    (eff_len),
  .len_q      (len_q)
);

// File: tb/vlen_ctl_reg_tb.sv
module vlen_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr;
  logic [1:0]  req_op0;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn, req_crm;
  logic [2:0]  req_op2;
  logic [1:0]  req_el;
  logic        trap_en;
  logic [63:0] wr_data;
  logic [3:0]  sup_mask;
  logic [63:0] rd_data;
  logic        rd_vld, undef, trap;
  logic [5:0]  trap_class;
  logic [3:0]  eff_len;

  int total = 0;
  int bad   = 0;
  logic [3:0] m_len;

  always #2 clk = ~clk;

  vlen_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .req_el(req_el),
    .trap_en(trap_en), .wr_data(wr_data), .sup_mask(sup_mask),
    .rd_data(rd_data), .rd_vld(rd_vld), .undef(undef), .trap(trap),
    .trap_class(trap_class), .eff_len(eff_len)
  );

  function automatic logic [3:0] exp_eff(logic [3:0] len, logic [3:0] mask);
    int units = int'(len) + 1;
    int best  = 0;
    for (int k = 1; k <= 4; k++) begin
      if (mask[k-1] && (1 << k) <= units) best = k;
    end
    return 4'((1 << best) - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_enc(bit good);
    req_op0 = 2'b11; req_op1 = 3'b110; req_crn = 4'b0001;
    req_crm = 4'b0010; req_op2 = 3'b000;
    if (!good) begin
      case ($urandom_range(0, 4))
        0: req_op0 = 2'b10;
        1: req_op1 = 3'b111;
        2: req_crn = 4'b0011;
        3: req_crm = 4'b0000;
        default: req_op2 = 3'b001;
      endcase
    end
  endtask

  // One access: drive at negedge, check outputs, then commit at posedge.
  task automatic access(bit wr, logic [1:0] el, bit en, bit good,
                        logic [63:0] data, logic [3:0] mask);
    bit hit, ok;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_el = el; trap_en = en;
    wr_data = data; sup_mask = mask;
    set_enc(good);
    #1;
    hit = good;
    ok  = hit && el == 2'd3 && en;
    chk(eff_len == exp_eff(m_len, mask), "R7/R8 eff_len", 64'(eff_len), 64'(exp_eff(m_len, mask)));
    if (!hit) begin
      chk(!rd_vld && !undef && !trap, "R4 no response", {61'b0, rd_vld, undef, trap}, 64'd0);
    end else if (el != 2'd3) begin
      chk(undef && !rd_vld && !trap, "R5 undef", {61'b0, rd_vld, undef, trap}, 64'd2);
    end else if (!en) begin
      chk(trap && !rd_vld && !undef, "R6 trap", {61'b0, rd_vld, undef, trap}, 64'd1);
      chk(trap_class == 6'h19, "R6 class", 64'(trap_class), 64'h19);
    end else if (!wr) begin
      chk(rd_vld && rd_data == {60'b0, m_len}, "R3 read", rd_data, {60'b0, m_len});
    end
    if (!trap) chk(trap_class == 6'h00, "R9 class idle", 64'(trap_class), 64'd0);
    if (!rd_vld) chk(rd_data == 64'd0, "R3 rd_data idle", rd_data, 64'd0);
    @(posedge clk);
    if (ok && wr) m_len = data[3:0];
  endtask

  task automatic read_back(string req);
    access(1'b0, 2'd3, 1'b1, 1'b1, 64'd0, 4'hF);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0; req_el = 2'd0; trap_en = 1'b0;
    wr_data = '0; sup_mask = 4'hF;
    set_enc(1'b1);
    m_len = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(eff_len == 4'd0, "R1 eff_len", 64'(eff_len), 64'd0);
    read_back("R1");

    // R2: full-width write keeps only low code; R3 upper bits zero
    access(1'b1, 2'd3, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 4'hF);
    read_back("R2");
    chk(m_len == 4'd9, "R2 model", 64'(m_len), 64'd9);

    // R8: eff_len changes right after the write edge, not before
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_el = 2'd3; trap_en = 1'b1;
    wr_data = 64'hF; sup_mask = 4'hF; set_enc(1'b1);
    #1;
    chk(eff_len == 4'd7, "R8 before edge", 64'(eff_len), 64'd7);
    @(posedge clk);
    m_len = 4'hF;
    @(negedge clk);
    req_vld = 1'b0;
    #1;
    chk(eff_len == 4'hF, "R8 after edge", 64'(eff_len), 64'hF);

    // R7: partial masks
    access(1'b0, 2'd3, 1'b1, 1'b1, 64'd0, 4'b0011);   // 2048 req, up to 512 -> 3
    access(1'b1, 2'd3, 1'b1, 1'b1, 64'd4, 4'b0011);   // 640 req
    access(1'b0, 2'd3, 1'b1, 1'b1, 64'd0, 4'b0011);   // -> 512 -> 3
    access(1'b1, 2'd3, 1'b1, 1'b1, 64'd2, 4'b0000);   // 384 req
    access(1'b0, 2'd3, 1'b1, 1'b1, 64'd0, 4'b0000);   // only 128 -> 0
    access(1'b0, 2'd3, 1'b1, 1'b1, 64'd0, 4'b1111);   // -> 256 -> 1

    // R6: trapped write leaves the code
    access(1'b1, 2'd3, 1'b0, 1'b1, 64'd12, 4'hF);
    read_back("R6");
    // R5: undefined write at each lower level
    for (int e = 0; e < 3; e++) access(1'b1, 2'(e), 1'b1, 1'b1, 64'd13, 4'hF);
    read_back("R5");
    // R4: unmatched write
    access(1'b1, 2'd3, 1'b1, 1'b0, 64'd14, 4'hF);
    read_back("R4");
    chk(m_len == 4'd2, "R4/R5/R6 code kept", 64'(m_len), 64'd2);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      bit          wr   = 1'($urandom_range(0, 1));
      logic [1:0]  el   = ($urandom_range(0, 3) != 0) ? 2'd3 : 2'($urandom_range(0, 2));
      bit          en   = ($urandom_range(0, 4) != 0);
      bit          good = ($urandom_range(0, 4) != 0);
      logic [63:0] d    = {$urandom, $urandom};
      logic [3:0]  msk  = 4'($urandom_range(0, 15));
      access(wr, el, en, good, d, msk);
    end

    @(negedge clk);
    req_vld = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule